// File: doc/BRIEF.md
# Three-Level Call/Return Page Stack

This block is the flow-control unit that sits between an instruction decoder and the program ROM of a small microcontroller. It holds the active program counter (6 bits), the active page (4 bits) and the active chapter (2 bits), and drives their concatenation as the ROM address. A page buffer and a chapter buffer sit behind the active page and chapter. Software fills these buffers ahead of time, and a taken branch or call then commits them to the active address in one step.

Return addresses are kept in a three-level hardware stack. Each level holds a complete {chapter, page, PC} triple. A 3-bit valid latch records which levels hold live entries. A call shifts a one into the latch from the bottom, and a return shifts it right, so the call depth is encoded in the latch pattern and no stack pointer is kept. The decoder supplies one strobe each for branch, call and return, together with the status flag and the opcode. Sequential PC advance and the buffer-loading instructions arrive on plain load ports.

Top module: `pgstk_ctrl`

## Requirements
- R1: While reset is active, and after it is released, the ROM address reads 0x3C0. This means the chapter is 0, the page is 0xF and the PC is 0. The page buffer resets to 0xF, the chapter buffer resets to 0, and the stack is empty.
- R2: `rom_addr` is {chapter, page, PC}, with the chapter in bits 11:10, the page in bits 9:6 and the PC in bits 5:0.
- R3: A branch strobe with status high has three effects. The PC takes opcode bits 5:0, the page takes the page buffer, and the chapter takes the chapter buffer.
- R4: A branch strobe with status low leaves the page and chapter unchanged. The PC follows the PC load port as usual.
- R5: A call strobe with status high pushes the current {chapter, page, PC} onto the stack and shifts a one into the valid latch. It then loads the PC from opcode bits 5:0 and commits both buffers to the active page and chapter.
- R6: A call strobe with status low copies the active page into the page buffer and the active chapter into the chapter buffer. The active address does not change.
- R7: A return strobe with a live top level pops the newest entry into the PC. The popped page goes to both the page and the page buffer, and the popped chapter goes to both the chapter and the chapter buffer. The valid latch shifts right.
- R8: A return strobe with no live level changes nothing.
- R9: A fourth nested call silently discards the oldest entry. Three returns then restore the three newest entries, newest first, and a fourth return has no effect.
- R10: The PC, page buffer and chapter buffer load ports take effect at the next edge. The exception is a register that a control action writes in the same cycle: in that case the control action wins.
- R11: When several strobes are high together, only one acts. Branch has priority over call, and call has priority over return.
- R12: Every effect appears on `rom_addr` right after the clock edge at which the strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_req | input | 1 | Decoded branch strobe |
| call_req | input | 1 | Decoded call strobe |
| ret_req | input | 1 | Decoded return strobe |
| status_in | input | 1 | Status flag that conditions branch and call |
| opcode | input | 8 | Current opcode; the low 6 bits are the target PC |
| pc_ld | input | 1 | Load the PC from `pc_ld_val` |
| pc_ld_val | input | 6 | Next sequential PC value |
| pbuf_ld | input | 1 | Load the page buffer |
| pbuf_ld_val | input | 4 | Page buffer value |
| cbuf_ld | input | 1 | Load the chapter buffer |
| cbuf_ld_val | input | 2 | Chapter buffer value |
| rom_addr | output | 12 | ROM address {chapter, page, PC} |

## Verification
Branches are tried with status high and with status low, and with buffers that differ from the active page and chapter. This shows whether the buffer is committed or ignored. An untaken call is followed by a taken branch, which reveals whether the buffers were restored from the active address. Nested calls to depth four, followed by four returns, tell apart a shifting valid latch from a wrapping pointer and show that the oldest entry is lost. Simultaneous strobes, and loads in the same cycle as control actions, expose the priority order. A long pseudo-random stretch then mixes every pattern.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_BRANCH = 2'd1,
    ACT_CALL   = 2'd2,
    ACT_RET    = 2'd3
  } flow_act_e;
endpackage

// File: rtl/pgstk_stack.sv
module pgstk_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [DEPTH-1:0] live
);
  logic [W-1:0]     lvl_q [DEPTH];
  logic [W-1:0]     lvl_d [DEPTH];
  logic [DEPTH-1:0] live_q, live_d;
  logic             en;

  assign en = push | pop;

  // Shift register of levels: level 0 is the newest entry.
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    always_comb begin
      lvl_d[i] = lvl_q[i];
      if (push) begin
        if (i == 0) lvl_d[i] = din;
        else        lvl_d[i] = lvl_q[(i == 0) ? 0 : i-1];
      end else if (pop) begin
        if (i == DEPTH-1) lvl_d[i] = '0;
        else              lvl_d[i] = lvl_q[(i == DEPTH-1) ? i : i+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lvl_q[i] <= '0;
      else if (en) lvl_q[i] <= lvl_d[i];
    end
  end

  always_comb begin
    live_d = live_q;
    if (push)     live_d = {live_q[DEPTH-2:0], 1'b1};
    else if (pop) live_d = live_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  live_q <= '0;
    else if (en) live_q <= live_d;
  end

  assign dout = lvl_q[0];
  assign live = live_q;
endmodule

// File: rtl/pgstk_regs.sv
module pgstk_regs #(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4,
  parameter int CHAP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_take,
  input  logic              call_skip,
  input  logic              ret_take,
  input  logic [PC_W-1:0]   jump_pc,
  input  logic [PC_W-1:0]   pop_pc,
  input  logic [PAGE_W-1:0] pop_page,
  input  logic [CHAP_W-1:0] pop_chap,
  input  logic              pc_ld,
  input  logic [PC_W-1:0]   pc_ld_val,
  input  logic              pbuf_ld,
  input  logic [PAGE_W-1:0] pbuf_ld_val,
  input  logic              cbuf_ld,
  input  logic [CHAP_W-1:0] cbuf_ld_val,
  output logic [PC_W-1:0]   pc,
  output logic [PAGE_W-1:0] page,
  output logic [PAGE_W-1:0] pbuf,
  output logic [CHAP_W-1:0] chap,
  output logic [CHAP_W-1:0] cbuf
);
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [PAGE_W-1:0] page_q, page_d, pbuf_q, pbuf_d;
  logic [CHAP_W-1:0] chap_q, chap_d, cbuf_q, cbuf_d;
  logic              upd;

  assign upd = jump_take | call_skip | ret_take | pc_ld | pbuf_ld | cbuf_ld;

  always_comb begin
    pc_d   = pc_q;
    page_d = page_q;
    chap_d = chap_q;
    pbuf_d = pbuf_q;
    cbuf_d = cbuf_q;
    if (pc_ld)   pc_d   = pc_ld_val;
    if (pbuf_ld) pbuf_d = pbuf_ld_val;
    if (cbuf_ld) cbuf_d = cbuf_ld_val;
    if (jump_take) begin
      pc_d   = jump_pc;
      page_d = pbuf_q;
      chap_d = cbuf_q;
    end
    if (call_skip) begin
      pbuf_d = page_q;
      cbuf_d = chap_q;
    end
    if (ret_take) begin
      pc_d   = pop_pc;
      page_d = pop_page;
      pbuf_d = pop_page;
      chap_d = pop_chap;
      cbuf_d = pop_chap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      page_q <= '1;
      pbuf_q <= '1;
      chap_q <= '0;
      cbuf_q <= '0;
    end else if (upd) begin
      pc_q   <= pc_d;
      page_q <= page_d;
      pbuf_q <= pbuf_d;
      chap_q <= chap_d;
      cbuf_q <= cbuf_d;
    end
  end

  assign pc   = pc_q;
  assign page = page_q;
  assign pbuf = pbuf_q;
  assign chap = chap_q;
  assign cbuf = cbuf_q;
endmodule

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl #(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4,
  parameter int CHAP_W = 2,
  parameter int OP_W   = 8,
  parameter int DEPTH  = 3,
  localparam int ADDR_W = CHAP_W + PAGE_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              status_in,
  input  logic [OP_W-1:0]   opcode,
  input  logic              pc_ld,
  input  logic [PC_W-1:0]   pc_ld_val,
  input  logic              pbuf_ld,
  input  logic [PAGE_W-1:0] pbuf_ld_val,
  input  logic              cbuf_ld,
  input  logic [CHAP_W-1:0] cbuf_ld_val,
  output logic [ADDR_W-1:0] rom_addr
);
  import pgstk_pkg::*;

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  flow_act_e         act;
  logic              br_take, call_take, call_skip, ret_take;
  logic [PC_W-1:0]   pc;
  logic [PAGE_W-1:0] page, pbuf;
  logic [CHAP_W-1:0] chap, cbuf;
  logic [ADDR_W-1:0] top_entry;
  logic [DEPTH-1:0]  live;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  // Fixed priority among strobes: branch, then call, then return.
  always_comb begin
    if (br_req)        act = ACT_BRANCH;
    else if (call_req) act = ACT_CALL;
    else if (ret_req)  act = ACT_RET;
    else               act = ACT_NONE;
  end

  assign br_take   = (act == ACT_BRANCH) &&  status_in;
  assign call_take = (act == ACT_CALL)   &&  status_in;
  assign call_skip = (act == ACT_CALL)   && !status_in;
  assign ret_take  = (act == ACT_RET)    &&  live[0];

  pgstk_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (core_rst_n),
    .push  (call_take),
    .pop   (ret_take),
    .din   ({chap, page, pc}),
    .dout  (top_entry),
    .live  (live)
  );

  pgstk_regs #(.PC_W(PC_W), .PAGE_W(PAGE_W), .CHAP_W(CHAP_W)) u_regs (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .jump_take   (br_take | call_take),
    .call_skip   (call_skip),
    .ret_take    (ret_take),
    .jump_pc     (opcode[PC_W-1:0]),
    .pop_pc      (top_entry[PC_W-1:0]),
    .pop_page    (top_entry[PC_W +: PAGE_W]),
    .pop_chap    (top_entry[PC_W+PAGE_W +: CHAP_W]),
    .pc_ld       (pc_ld),
    .pc_ld_val   (pc_ld_val),
    .pbuf_ld     (pbuf_ld),
    .pbuf_ld_val (pbuf_ld_val),
    .cbuf_ld     (cbuf_ld),
    .cbuf_ld_val (cbuf_ld_val),
    .pc          (pc),
    .page        (page),
    .pbuf        (pbuf),
    .chap        (chap),
    .cbuf        (cbuf)
  );

  assign rom_addr = {chap, page, pc};
endmodule

// File: rtl/pgstk_ctrl_chk.sv
module pgstk_ctrl_chk #(
  parameter int PC_W   = 6,
  parameter int PAGE_W = 4,
  parameter int CHAP_W = 2,
  parameter int OP_W   = 8,
  parameter int DEPTH  = 3,
  localparam int ADDR_W = CHAP_W + PAGE_W + PC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_req,
  input logic              call_req,
  input logic              ret_req,
  input logic              status_in,
  input logic [OP_W-1:0]   opcode,
  input logic              pc_ld,
  input logic              pbuf_ld,
  input logic              cbuf_ld,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [PAGE_W-1:0] pbuf,
  input logic [CHAP_W-1:0] cbuf,
  input logic [DEPTH-1:0]  live
);
  a_r3_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && status_in) |=> rom_addr[PC_W-1:0] == $past(opcode[PC_W-1:0]));

  a_r3_branch_page: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && status_in) |=> rom_addr[PC_W +: PAGE_W] == $past(pbuf)
                           && rom_addr[PC_W+PAGE_W +: CHAP_W] == $past(cbuf));

  a_r5_call_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && call_req && status_in) |=> live == {$past(live[DEPTH-2:0]), 1'b1});

  a_r6_skip_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && call_req && !status_in) |=>
      pbuf == $past(rom_addr[PC_W +: PAGE_W]) && cbuf == $past(rom_addr[PC_W+PAGE_W +: CHAP_W]));

  a_r7_pop_buffers: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && !call_req && ret_req && live[0]) |=>
      pbuf == rom_addr[PC_W +: PAGE_W] && cbuf == rom_addr[PC_W+PAGE_W +: CHAP_W]);

  a_r8_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && !call_req && ret_req && !live[0] && !pc_ld && !pbuf_ld && !cbuf_ld) |=>
      $stable(rom_addr) && $stable(pbuf) && $stable(cbuf) && $stable(live));
endmodule

bind pgstk_ctrl pgstk_ctrl_chk #(
  .PC_W(PC_W), .PAGE_W(PAGE_W), .CHAP_W(CHAP_W), .OP_W(OP_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .br_req    (br_req),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .status_in (status_in),
  .opcode    (opcode),
  .pc_ld     (pc_ld),
  .pbuf_ld   (pbuf_ld),
  .cbuf_ld   (cbuf_ld),
  .rom_addr  (rom_addr),
  .pbuf      (pbuf),
  .cbuf      (cbuf),
  .live      (live)
);

// File: tb/pgstk_ctrl_test.sv
module pgstk_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_req, call_req, ret_req, status_in;
  logic [7:0]  opcode;
  logic        pc_ld, pbuf_ld, cbuf_ld;
  logic [5:0]  pc_ld_val;
  logic [3:0]  pbuf_ld_val;
  logic [1:0]  cbuf_ld_val;
  logic [11:0] rom_addr;

  int checks = 0;
  int fails  = 0;

  // Reference state
  int m_pc, m_page, m_pbuf, m_chap, m_cbuf;
  int stk[$];

  always #4 clk = ~clk;

  pgstk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .call_req(call_req), .ret_req(ret_req),
    .status_in(status_in), .opcode(opcode), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
    .pbuf_ld(pbuf_ld), .pbuf_ld_val(pbuf_ld_val), .cbuf_ld(cbuf_ld),
    .cbuf_ld_val(cbuf_ld_val), .rom_addr(rom_addr)
  );

  function automatic int expected();
    return (m_chap << 10) | (m_page << 6) | m_pc;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rom_addr !== 12'(expected())) begin
      fails++;
      $display("FAIL %s rom_addr actual %03h expected %03h", tag, rom_addr, expected());
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_page = 15; m_pbuf = 15; m_chap = 0; m_cbuf = 0;
    stk.delete();
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks after the edge.
  task automatic step(input string tag, input bit b, input bit c, input bit r, input bit s,
                      input int op, input bit pl, input int pv, input bit bl, input int bv,
                      input bit cl, input int cv);
    int n_pc, n_page, n_pbuf, n_chap, n_cbuf;
    br_req = b; call_req = c; ret_req = r; status_in = s; opcode = 8'(op);
    pc_ld = pl; pc_ld_val = 6'(pv); pbuf_ld = bl; pbuf_ld_val = 4'(bv);
    cbuf_ld = cl; cbuf_ld_val = 2'(cv);
    @(posedge clk);
    n_pc = pl ? pv : m_pc; n_pbuf = bl ? bv : m_pbuf; n_cbuf = cl ? cv : m_cbuf;
    n_page = m_page; n_chap = m_chap;
    if (b) begin
      if (s) begin n_pc = op & 63; n_page = m_pbuf; n_chap = m_cbuf; end
    end else if (c) begin
      if (s) begin
        stk.push_front((m_chap << 10) | (m_page << 6) | m_pc);
        if (stk.size() > 3) void'(stk.pop_back());
        n_pc = op & 63; n_page = m_pbuf; n_chap = m_cbuf;
      end else begin
        n_pbuf = m_page; n_cbuf = m_chap;
      end
    end else if (r && stk.size() > 0) begin
      int e;
      e = stk.pop_front();
      n_pc = e & 63; n_page = (e >> 6) & 15; n_chap = (e >> 10) & 3;
      n_pbuf = n_page; n_cbuf = n_chap;
    end
    m_pc = n_pc; m_page = n_page; m_pbuf = n_pbuf; m_chap = n_chap; m_cbuf = n_cbuf;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ld_all(input string tag, input int pv, input int bv, input int cv);
    step(tag, 0, 0, 0, 0, 0, 1, pv, 1, bv, 1, cv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    br_req = 0; call_req = 0; ret_req = 0; status_in = 0; opcode = '0;
    pc_ld = 0; pc_ld_val = '0; pbuf_ld = 0; pbuf_ld_val = '0; cbuf_ld = 0; cbuf_ld_val = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");
    idle("R1 idle");

    // R2: field placement via PC load only
    step("R2 pc field", 0, 0, 0, 0, 0, 1, 6'h15, 0, 0, 0, 0);
    // R10: loads of all three
    ld_all("R10 loads", 6'h07, 4'hA, 2);
    // R3: taken branch commits buffers
    step("R3 taken branch", 1, 0, 0, 1, 8'hEA, 0, 0, 0, 0, 0, 0);
    // R4: untaken branch, PC follows load
    step("R4 untaken branch", 1, 0, 0, 0, 8'h11, 1, 6'h2B, 1, 4'h3, 1, 1);
    // R6: untaken call restores buffers, then a taken branch exposes them
    step("R6 untaken call", 0, 1, 0, 0, 8'h05, 0, 0, 0, 0, 0, 0);
    step("R6 branch shows restored buffers", 1, 0, 0, 1, 8'h05, 0, 0, 0, 0, 0, 0);
    // R8: return with empty stack
    step("R8 empty return", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R5/R7: one call and return
    ld_all("R10 setup", 6'h09, 4'h3, 1);
    step("R5 taken call", 0, 1, 0, 1, 8'h3C, 0, 0, 0, 0, 0, 0);
    step("R7 return", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 buffers via branch", 1, 0, 0, 1, 8'h01, 0, 0, 0, 0, 0, 0);
    // R9: four nested calls and four returns
    for (int i = 0; i < 4; i++) begin
      ld_all("R9 setup", 10 + i, 4 + i, i & 3);
      step("R9 nested call", 0, 1, 0, 1, 8'h20 + i, 0, 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < 4; i++) step("R9 unwind", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: branch and call together act as branch only; then return is empty
    ld_all("R11 setup", 6'h01, 4'h6, 3);
    step("R11 br+call+ret", 1, 1, 1, 1, 8'h12, 0, 0, 0, 0, 0, 0);
    step("R11 no push happened", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R11 call over return", 0, 1, 1, 1, 8'h33, 0, 0, 0, 0, 0, 0);
    // R10: load during taken call; control owns PC and page
    step("R10 call with loads", 0, 1, 0, 1, 8'h0E, 1, 6'h3F, 1, 4'h9, 1, 2);
    step("R10 load buffer visible", 1, 0, 0, 1, 8'h02, 0, 0, 0, 0, 0, 0);
    // R12: mixed pseudo-random stimulus
    for (int i = 0; i < 400; i++) begin
      int v;
      v = int'($urandom);
      step("R12 random", v[0] & v[1], v[2] & v[3], v[4], v[5], v[13:6], v[14], v[20:15],
           v[21], v[25:22], v[26], v[28:27]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule